// File: doc/BRIEF.md
# Shared-Setting First-Order DC-Blocking Filter

This block applies one first-order recursive filter to every channel of an interleaved multi-channel record stream. It removes DC offset and low-frequency noise. Samples arrive one at a time, each with a channel index and a valid strobe. Each channel keeps its own one-sample history of input and output. All channels share a single filter setting, so only the history is stored per channel.

A 2-bit mode input chooses the setting. Three modes use built-in coefficient sets whose cutoffs are fixed fractions of the sample rate. One mode uses three 32-bit coefficients loaded by the host through a small write port. After reset those coefficients form a unity all-pass, so programmable mode passes samples through untouched until the host loads a real response. Coefficient writes take effect only while the record channels are all powered down. Any change of mode clears the history of every channel.

Top module: `hpf_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0. Reset restores the mode register to 2'b01 and the programmable coefficients to ff0 = 0x7FFFFFFF, ff1 = 0, fb1 = 0.
- R2: A sample presented with `in_valid` = 1 and `in_ch` < NUM_CH produces `out_valid` = 1 exactly one cycle later, with `out_ch` equal to that `in_ch`. A sample whose channel index is NUM_CH or above produces no output and does not disturb any state.
- R3: Each output is y = (ff0·x + ff1·xp + fb1·yp + 2^30) >>> 31. The arithmetic uses 64 bits. The coefficients are signed Q1.31. xp and yp are the previous input and previous output of the same channel.
- R4: The result is saturated to the signed SAMPLE_W range instead of wrapping. The saturated value is also the value stored as yp.
- R5: In mode 2'b00, with the reset coefficients, every output equals its input.
- R6: A coefficient write uses `cfg_addr` 0 for ff0, 1 for ff1 and 2 for fb1. Address 3 is ignored. A write is also ignored while `rec_active` is 1.
- R7: The programmable coefficients affect the output only in mode 2'b00.
- R8: Modes 2'b01, 2'b10 and 2'b11 use step values k = 269864, 3373268 and 26986288. Their coefficients are ff0 = 2^31 − k/2, ff1 = −ff0 and fb1 = 2^31 − k. These give cutoffs near 0.00002, 0.00025 and 0.002 of the sample rate.
- R9: In modes 2'b11 and 2'b10, a constant input on a channel drives that channel's output down to a small residue, at most 41 and 320 LSB respectively.
- R10: Each channel's output depends only on that channel's own sample history.
- R11: In a cycle where `hpf_sel` differs from the mode used in the previous cycle, every channel's history is treated as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hpf_sel | input | 2 | Filter mode: 00 programmable, 01/10/11 fixed cutoffs |
| rec_active | input | 1 | High while any record channel is powered; blocks coefficient writes |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 2 | Coefficient select: 0 ff0, 1 ff1, 2 fb1 |
| cfg_data | input | 32 | Coefficient value, signed Q1.31 |
| in_valid | input | 1 | Input sample strobe |
| in_ch | input | CH_W | Channel index of the input sample |
| in_data | input | SAMPLE_W | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_ch | output | CH_W | Channel index of the output sample |
| out_data | output | SAMPLE_W | Signed, saturated output sample |

## Verification
The bench builds the block with SAMPLE_W = 16 and NUM_CH = 3. The narrow sample width lets two near-unity programmable taps drive the sum past full scale, which exercises saturation in both directions. With three channels on a 2-bit index, the value 3 is a real out-of-range index, so the drop path can be tested. The fixed modes settle fast enough at this width that constant-input rejection runs to its residue within a few thousand samples per channel. A behavioural model computes the expected result for every cycle.

// File: rtl/hpf_pkg.sv
package hpf_pkg;

    localparam int COEF_W    = 32;
    localparam int ACC_W     = 64;
    localparam int FRAC_BITS = COEF_W - 1;

    typedef enum logic [1:0] {
        MODE_PROG = 2'b00,
        MODE_SLOW = 2'b01,
        MODE_MID  = 2'b10,
        MODE_FAST = 2'b11
    } hpf_mode_e;

    typedef enum logic [1:0] {
        CSEL_FF0  = 2'd0,
        CSEL_FF1  = 2'd1,
        CSEL_FB1  = 2'd2,
        CSEL_NONE = 2'd3
    } coef_sel_e;

    typedef struct packed {
        logic signed [COEF_W-1:0] ff0;
        logic signed [COEF_W-1:0] ff1;
        logic signed [COEF_W-1:0] fb1;
    } coef_set_t;

    localparam logic signed [COEF_W-1:0] FF0_RST = 32'h7FFF_FFFF;
    localparam logic signed [COEF_W-1:0] FF1_RST = 32'h0000_0000;
    localparam logic signed [COEF_W-1:0] FB1_RST = 32'h0000_0000;

    // Distance of the pole below unity, in Q1.31 LSBs, per fixed mode.
    function automatic logic [COEF_W:0] mode_step(hpf_mode_e m);
        case (m)
            MODE_SLOW: return 33'd269864;
            MODE_MID:  return 33'd3373268;
            MODE_FAST: return 33'd26986288;
            default:   return 33'd0;
        endcase
    endfunction

    // Built-in set: pole a = 1 - k, zero at DC, unity gain at Nyquist.
    function automatic coef_set_t fixed_coefs(hpf_mode_e m);
        coef_set_t       c;
        logic [COEF_W:0] unity;
        logic [COEF_W:0] k;
        unity  = 33'd1 << FRAC_BITS;
        k      = mode_step(m);
        c.ff0  = COEF_W'(unity - (k >> 1));
        c.ff1  = -c.ff0;
        c.fb1  = COEF_W'(unity - k);
        return c;
    endfunction

    function automatic coef_set_t reset_coefs();
        coef_set_t c;
        c.ff0 = FF0_RST;
        c.ff1 = FF1_RST;
        c.fb1 = FB1_RST;
        return c;
    endfunction

endpackage

// File: rtl/hpf_coef_bank.sv
module hpf_coef_bank
    import hpf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                lock,
    input  logic                wr_en,
    input  coef_sel_e           wr_sel,
    input  logic [COEF_W-1:0]   wr_data,
    output coef_set_t           prog
);

    coef_set_t prog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= reset_coefs();
        end else if (wr_en && !lock) begin
            case (wr_sel)
                CSEL_FF0: prog_q.ff0 <= wr_data;
                CSEL_FF1: prog_q.ff1 <= wr_data;
                CSEL_FB1: prog_q.fb1 <= wr_data;
                default:  ;
            endcase
        end
    end

    assign prog = prog_q;

    assert_lock_R6: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(prog_q));

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (prog_q.ff0 == FF0_RST && prog_q.ff1 == FF1_RST && prog_q.fb1 == FB1_RST));

endmodule

// File: rtl/hpf_coef_mux.sv
module hpf_coef_mux
    import hpf_pkg::*;
(
    input  hpf_mode_e  mode,
    input  coef_set_t  prog,
    output coef_set_t  active
);

    coef_set_t fixed;

    always_comb begin
        fixed = fixed_coefs(mode);
        if (mode == MODE_PROG) active = prog;
        else                   active = fixed;
    end

endmodule

// File: rtl/hpf_hist.sv
module hpf_hist #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 24,
    parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic [CH_W-1:0]            rd_ch,
    output logic signed [SAMPLE_W-1:0] rd_x,
    output logic signed [SAMPLE_W-1:0] rd_y,
    input  logic                       wr_en,
    input  logic [CH_W-1:0]            wr_ch,
    input  logic signed [SAMPLE_W-1:0] wr_x,
    input  logic signed [SAMPLE_W-1:0] wr_y
);

    logic signed [SAMPLE_W-1:0] x_q [NUM_CH];
    logic signed [SAMPLE_W-1:0] y_q [NUM_CH];
    logic [NUM_CH-1:0]          nz;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                x_q[g] <= '0;
                y_q[g] <= '0;
            end else if (wr_en && wr_ch == CH_W'(g)) begin
                x_q[g] <= wr_x;
                y_q[g] <= wr_y;
            end else if (flush) begin
                x_q[g] <= '0;
                y_q[g] <= '0;
            end
        end
        assign nz[g] = (x_q[g] != '0) || (y_q[g] != '0);
    end

    always_comb begin
        rd_x = '0;
        rd_y = '0;
        if (!flush) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (rd_ch == CH_W'(i)) begin
                    rd_x = x_q[i];
                    rd_y = y_q[i];
                end
            end
        end
    end

    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (flush && !wr_en) |=> (nz == '0));

endmodule

// File: rtl/hpf_mac.sv
module hpf_mac
    import hpf_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  coef_set_t                  coef,
    input  logic signed [SAMPLE_W-1:0] x,
    input  logic signed [SAMPLE_W-1:0] xp,
    input  logic signed [SAMPLE_W-1:0] yp,
    output logic signed [SAMPLE_W-1:0] y
);

    localparam logic signed [ACC_W-1:0] HALF = 64'sd1 <<< (FRAC_BITS - 1);
    localparam logic signed [ACC_W-1:0] YMAX = (64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1;
    localparam logic signed [ACC_W-1:0] YMIN = -(64'sd1 <<< (SAMPLE_W - 1));

    logic signed [ACC_W-1:0] t0, t1, t2, acc, q;

    always_comb begin
        t0  = ACC_W'(coef.ff0) * ACC_W'(x);
        t1  = ACC_W'(coef.ff1) * ACC_W'(xp);
        t2  = ACC_W'(coef.fb1) * ACC_W'(yp);
        acc = t0 + t1 + t2;
        q   = (acc + HALF) >>> FRAC_BITS;
        if (q > YMAX)      y = YMAX[SAMPLE_W-1:0];
        else if (q < YMIN) y = YMIN[SAMPLE_W-1:0];
        else               y = q[SAMPLE_W-1:0];
    end

endmodule

// File: rtl/hpf_top.sv
module hpf_top
    import hpf_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 24,
    parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 hpf_sel,
    input  logic                       rec_active,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_addr,
    input  logic [31:0]                cfg_data,
    input  logic                       in_valid,
    input  logic [CH_W-1:0]            in_ch,
    input  logic signed [SAMPLE_W-1:0] in_data,
    output logic                       out_valid,
    output logic [CH_W-1:0]            out_ch,
    output logic signed [SAMPLE_W-1:0] out_data
);

    localparam logic [CH_W:0] CH_LIMIT = (CH_W + 1)'(NUM_CH);

    hpf_mode_e                  mode_now, mode_q;
    logic                       flush, accept;
    coef_set_t                  prog, active;
    logic signed [SAMPLE_W-1:0] xp, yp, y_new;

    assign mode_now = hpf_mode_e'(hpf_sel);
    assign flush    = (mode_now != mode_q);
    assign accept   = in_valid && ({1'b0, in_ch} < CH_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_SLOW;
        else     mode_q <= mode_now;
    end

    hpf_coef_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .lock    (rec_active),
        .wr_en   (cfg_we),
        .wr_sel  (coef_sel_e'(cfg_addr)),
        .wr_data (cfg_data),
        .prog    (prog)
    );

    hpf_coef_mux u_mux (
        .mode   (mode_now),
        .prog   (prog),
        .active (active)
    );

    hpf_hist #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CH_W(CH_W)) u_hist (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .rd_ch (in_ch),
        .rd_x  (xp),
        .rd_y  (yp),
        .wr_en (accept),
        .wr_ch (in_ch),
        .wr_x  (in_data),
        .wr_y  (y_new)
    );

    hpf_mac #(.SAMPLE_W(SAMPLE_W)) u_mac (
        .coef (active),
        .x    (in_data),
        .xp   (xp),
        .yp   (yp),
        .y    (y_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_ch    <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_ch   <= in_ch;
                out_data <= y_new;
            end
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (out_valid && out_ch == $past(in_ch)));

    assert_drop_R2: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !out_valid);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/tb_hpf_top.sv
module tb_hpf_top;

    localparam int NCH = 3;
    localparam int SW  = 16;
    localparam int CW  = 2;

    logic                 clk = 0;
    logic                 rst = 1;
    logic [1:0]           hpf_sel = 2'b01;
    logic                 rec_active = 0;
    logic                 cfg_we = 0;
    logic [1:0]           cfg_addr = 0;
    logic [31:0]          cfg_data = 0;
    logic                 in_valid = 0;
    logic [CW-1:0]        in_ch = 0;
    logic signed [SW-1:0] in_data = 0;
    logic                 out_valid;
    logic [CW-1:0]        out_ch;
    logic signed [SW-1:0] out_data;

    hpf_top #(.NUM_CH(NCH), .SAMPLE_W(SW), .CH_W(CW)) dut (
        .clk(clk), .rst(rst), .hpf_sel(hpf_sel), .rec_active(rec_active),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
        .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data)
    );

    always #4 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string cur_req = "R1";

    // behavioural reference state
    longint p0, p1, p2;
    longint hx [NCH];
    longint hy [NCH];
    logic [1:0] m_mode;
    bit     e_valid;
    int     e_ch;
    longint e_data;
    longint c0, c1, c2, acc, yv, kk;

    function automatic longint sx32(logic [31:0] v);
        return longint'($signed(v));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            p0 = 64'h7FFF_FFFF; p1 = 0; p2 = 0;
            for (int i = 0; i < NCH; i++) begin hx[i] = 0; hy[i] = 0; end
            m_mode  = 2'b01;
            e_valid = 0;
        end else begin
            if (hpf_sel != m_mode)
                for (int i = 0; i < NCH; i++) begin hx[i] = 0; hy[i] = 0; end
            m_mode = hpf_sel;
            if (hpf_sel == 2'b00) begin
                c0 = p0; c1 = p1; c2 = p2;
            end else begin
                kk = (hpf_sel == 2'b01) ? 269864 : (hpf_sel == 2'b10) ? 3373268 : 26986288;
                c0 = (64'sd1 <<< 31) - kk / 2;
                c1 = -c0;
                c2 = (64'sd1 <<< 31) - kk;
            end
            e_valid = in_valid && (int'(in_ch) < NCH);
            if (e_valid) begin
                e_ch = int'(in_ch);
                acc  = c0 * longint'(in_data) + c1 * hx[e_ch] + c2 * hy[e_ch];
                yv   = (acc + (64'sd1 <<< 30)) >>> 31;
                if (yv > 32767)  yv = 32767;
                if (yv < -32768) yv = -32768;
                e_data   = yv;
                hx[e_ch] = longint'(in_data);
                hy[e_ch] = yv;
            end
            if (cfg_we && !rec_active) begin
                case (cfg_addr)
                    2'd0: p0 = sx32(cfg_data);
                    2'd1: p1 = sx32(cfg_data);
                    2'd2: p2 = sx32(cfg_data);
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            n_cmp++;
            if (out_valid !== e_valid ||
                (e_valid && (int'(out_ch) != e_ch || longint'(out_data) != e_data))) begin
                n_bad++;
                $display("FAIL %s: cycle %0d out_valid=%0b ch=%0d data=%0d expected valid=%0b ch=%0d data=%0d",
                         cur_req, cyc, out_valid, out_ch, out_data, e_valid, e_ch, e_data);
            end
        end
    end

    task automatic chk(bit ok, string req, longint act, longint exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic put(int ch, int x);
        in_valid = 1; in_ch = CW'(ch); in_data = SW'(x);
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic idle(int n);
        in_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        cfg_we = 1; cfg_addr = 2'(a); cfg_data = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    longint last [NCH];

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        idle(1);
        chk(out_valid == 0, "R1", out_valid, 0);

        // R5: reset coefficients in programmable mode pass samples unchanged
        cur_req = "R5";
        hpf_sel = 2'b00;
        idle(1);
        put(0, 12345);  chk(out_data == 12345,  "R5", out_data, 12345);
        put(1, -32768); chk(out_data == -32768, "R5", out_data, -32768);
        put(2, 32767);  chk(out_data == 32767,  "R5", out_data, 32767);
        put(0, -1);     chk(out_data == -1,     "R5", out_data, -1);

        // R2: latency and out-of-range channel drop
        cur_req = "R2";
        put(2, 77); chk(out_valid && out_ch == 2, "R2", out_ch, 2);
        put(3, 100); chk(out_valid == 0, "R2", out_valid, 0);

        // R3 / R6: half-gain coefficient, rounding half up
        cur_req = "R3";
        wr(0, 32'h4000_0000);
        put(0, 1000);  chk(out_data == 500,  "R3", out_data, 500);
        put(1, 1001);  chk(out_data == 501,  "R3", out_data, 501);
        put(2, -1001); chk(out_data == -500, "R3", out_data, -500);

        cur_req = "R6";
        rec_active = 1;
        wr(0, 32'h1000_0000);
        rec_active = 0;
        wr(3, 32'h1234_5678);
        put(0, 1000); chk(out_data == 500, "R6", out_data, 500);

        // R7 / R8: programmed ff0 has no effect in a fixed mode
        cur_req = "R7";
        hpf_sel = 2'b01;
        put(0, 1000); chk(out_data == 1000, "R7", out_data, 1000);

        // R4: saturation both ways
        cur_req = "R4";
        hpf_sel = 2'b00;
        wr(0, 32'h7FFF_FFFF);
        wr(1, 32'h7FFF_FFFF);
        put(0, 30000);  chk(out_data == 30000,  "R4", out_data, 30000);
        put(0, 30000);  chk(out_data == 32767,  "R4", out_data, 32767);
        put(0, -30000); chk(out_data == 0,      "R4", out_data, 0);
        put(0, -30000); chk(out_data == -32768, "R4", out_data, -32768);

        // R10: channels keep separate history
        cur_req = "R10";
        put(1, 100);
        put(2, 200);
        put(1, 100); chk(out_data == 200 && out_ch == 1, "R10", out_data, 200);
        put(2, 200); chk(out_data == 400 && out_ch == 2, "R10", out_data, 400);

        // R11: mode change wipes history
        cur_req = "R11";
        hpf_sel = 2'b10; idle(1);
        hpf_sel = 2'b00; idle(1);
        put(1, 1000); chk(out_data == 1000, "R11", out_data, 1000);

        // R9 / R8: constant-input rejection in the two faster modes
        cur_req = "R9";
        hpf_sel = 2'b11;
        for (int r = 0; r < 1300; r++) begin
            put(0, 30000);  last[0] = out_data;
            put(1, -20000); last[1] = out_data;
            put(2, 12345);  last[2] = out_data;
        end
        for (int i = 0; i < NCH; i++)
            chk(last[i] <= 41 && last[i] >= -41, "R9", last[i], 41);

        hpf_sel = 2'b10;
        for (int r = 0; r < 4000; r++) begin
            put(0, 30000);  last[0] = out_data;
            put(1, -20000); last[1] = out_data;
            put(2, 12345);  last[2] = out_data;
        end
        for (int i = 0; i < NCH; i++)
            chk(last[i] <= 320 && last[i] >= -320, "R9", last[i], 320);

        cur_req = "R8";
        hpf_sel = 2'b01;
        for (int r = 0; r < 200; r++) begin
            put(r % NCH, (r * 731) % 20000 - 10000);
        end
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule